// File: doc/BRIEF.md
# Bouncing Variable-Length Snake Register

This block drives an 18-bit output vector that always holds one unbroken run of set bits, the snake. A free-running divider on the single fast clock gives a step tick. On each tick the snake shifts one place in its current direction of travel. When a shift puts the head on the last bit at either end of the vector, the direction flips and later steps go the other way. Out of reset the snake is two bits long, sits at the least significant end and travels toward the most significant bit.

A single-cycle grow pulse, taken from a debounced push button, lengthens the snake by one segment. Lengths run 2, 3, 4, 5, 6 and then return to 2. When the length returns to 2, the two segments nearest the head stay and the four at the tail are removed. The vector, the direction, the length counter and the divider all update in one clocked domain, so each register has exactly one driver. When a grow pulse and a step tick arrive in the same cycle, the grow is applied and that step is dropped.

Top module: `snake_bounce`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `snake_o` equals 18'b11 (bits 1 and 0 set), and the direction of travel is toward bit 17.
- R2: The step tick fires on the DIV_TC-th rising edge after reset is released and then on every DIV_TC-th edge after that. On an edge with neither a tick nor a grow pulse, `snake_o` does not change.
- R3: On a tick with no grow pulse, the snake shifts by exactly one bit: toward bit 17 when travelling up, and toward bit 0 when travelling down.
- R4: A step that sets bit 17 while travelling up turns the direction to down. A step that sets bit 0 while travelling down turns it to up. The new direction applies from the next step.
- R5: A grow pulse below the maximum length adds one set bit next to the tail, which is the end opposite the direction of travel. The head stays where it is.
- R6: If the tail already occupies bit 0 (travelling up) or bit 17 (travelling down), a grow pulse adds the new bit next to the head instead, so the length still increases by one.
- R7: A grow pulse at length 6 sets the length to 2 and keeps only the two bits at the head end.
- R8: If a grow pulse and a step tick land on the same edge, only the grow takes effect. The step is lost and is not made up later.
- R9: `snake_o` is always a single contiguous run of set bits, and its population count equals the internal 3-bit length counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grow_i | input | 1 | Single-cycle request to lengthen the snake |
| snake_o | output | 18 | Snake bit pattern (VEC_W bits) |

## Verification
The hardest case to reach from the ports is a grow pulse that arrives while the tail sits on a vector edge. The snake passes through that state only for a few cycles, just after it reverses at either end and before its next step. A second hard case is a grow pulse that coincides exactly with a step tick. The stimulus reaches both by adapting to a reference model kept in the bench. In the later phase it watches the model's tail position and divider count, and it fires grow exactly when the tail touches an edge or a tick is due. Before that phase, a fixed mixed pattern of grow pulses sweeps lengths and positions across many bounces.

// File: rtl/snake_pkg.sv
package snake_pkg;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } snake_dir_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit <= 1) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/snake_tick_gen.sv
module snake_tick_gen #(
   parameter int unsigned DIV_TC = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);

   localparam int unsigned CNT_W = snake_pkg::cnt_width(DIV_TC);

   if (DIV_TC < 1) begin : g_bad_div
      $error("snake_tick_gen: DIV_TC must be at least 1");
   end

   if (DIV_TC == 1) begin : g_every_cycle
      logic tick_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) tick_q <= 1'b1;
         else         tick_q <= 1'b1;
      end

      assign tick_o = tick_q;

      // R2
      every_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         tick_o);
   end else begin : g_counter
      localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DIV_TC - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)          cnt_q <= RELOAD;
         else if (cnt_q == '0) cnt_q <= RELOAD;
         else                  cnt_q <= cnt_q - 1'b1;
      end

      assign tick_o = (cnt_q == '0);

      // R2
      cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         cnt_q <= RELOAD);
      // R2
      tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         tick_o |=> !tick_o);
   end

endmodule

// File: rtl/snake_len_ctrl.sv
module snake_len_ctrl #(
   parameter int unsigned MIN_LEN = 2,
   parameter int unsigned MAX_LEN = 6,
   parameter int unsigned LEN_W   = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             grow_i,
   output logic [LEN_W-1:0] len_o,
   output logic             wrap_o
);

   localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_LEN);
   localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_LEN);

   if (MIN_LEN < 1 || MAX_LEN <= MIN_LEN) begin : g_bad_range
      $error("snake_len_ctrl: need 1 <= MIN_LEN < MAX_LEN");
   end
   if ((1 << LEN_W) <= MAX_LEN) begin : g_bad_width
      $error("snake_len_ctrl: LEN_W too narrow for MAX_LEN");
   end

   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] len_d;
   logic             at_top;

   assign at_top = (len_q == LEN_HI);
   assign wrap_o = grow_i && at_top;

   always_comb begin
      len_d = len_q;
      if (grow_i) begin
         if (at_top) len_d = LEN_LO;
         else        len_d = len_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) len_q <= LEN_LO;
      else         len_q <= len_d;
   end

   assign len_o = len_q;

   // R7
   len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      len_o >= LEN_LO && len_o <= LEN_HI);
   // R7
   len_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> len_o == LEN_LO);
   // R5
   len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !grow_i |=> $stable(len_o));

endmodule

// File: rtl/snake_body.sv
module snake_body #(
   parameter int unsigned VEC_W   = 18,
   parameter int unsigned MIN_LEN = 2,
   parameter int unsigned MAX_LEN = 6
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 tick_i,
   input  logic                 grow_i,
   input  logic                 wrap_i,
   output logic [VEC_W-1:0]     vec_o,
   output snake_pkg::snake_dir_e dir_o
);
   import snake_pkg::*;

   localparam int unsigned      MSB   = VEC_W - 1;
   localparam int unsigned      TRIM  = MAX_LEN - MIN_LEN;
   localparam logic [VEC_W-1:0] START = VEC_W'((1 << MIN_LEN) - 1);

   if (VEC_W <= MAX_LEN + 1) begin : g_bad_width
      $error("snake_body: VEC_W must exceed MAX_LEN + 1");
   end

   logic [VEC_W-1:0] vec_q, vec_d;
   snake_dir_e       dir_q, dir_d;
   logic [VEC_W-1:0] toward_up, toward_down;
   logic             tail_on_edge;

   assign toward_up    = vec_q << 1;
   assign toward_down  = vec_q >> 1;
   assign tail_on_edge = (dir_q == DIR_UP) ? vec_q[0] : vec_q[MSB];

   always_comb begin
      vec_d = vec_q;
      dir_d = dir_q;
      if (grow_i) begin
         if (wrap_i) begin
            if (dir_q == DIR_UP) vec_d = vec_q & (vec_q << TRIM);
            else                 vec_d = vec_q & (vec_q >> TRIM);
         end else if (dir_q == DIR_UP) begin
            vec_d = tail_on_edge ? (vec_q | toward_up) : (vec_q | toward_down);
         end else begin
            vec_d = tail_on_edge ? (vec_q | toward_down) : (vec_q | toward_up);
         end
      end else if (tick_i) begin
         if (dir_q == DIR_UP) begin
            vec_d = toward_up;
            if (toward_up[MSB]) dir_d = DIR_DOWN;
         end else begin
            vec_d = toward_down;
            if (toward_down[0]) dir_d = DIR_UP;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vec_q <= START;
         dir_q <= DIR_UP;
      end else begin
         vec_q <= vec_d;
         dir_q <= dir_d;
      end
   end

   assign vec_o = vec_q;
   assign dir_o = dir_q;

   // R2
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i && !grow_i |=> $stable(vec_o) && $stable(dir_o));
   // R3
   step_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i && !grow_i |=> $countones(vec_o) == $countones($past(vec_o)) && vec_o != $past(vec_o));
   // R4
   top_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_o[MSB] |-> dir_o == DIR_DOWN);
   // R4
   bottom_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_o[0] |-> dir_o == DIR_UP);
   // R5
   grow_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grow_i && !wrap_i |=> $countones(vec_o) == $countones($past(vec_o)) + 1);

endmodule

// File: rtl/snake_bounce.sv
module snake_bounce #(
   parameter int unsigned VEC_W   = 18,
   parameter int unsigned MIN_LEN = 2,
   parameter int unsigned MAX_LEN = 6,
   parameter int unsigned DIV_TC  = 12_500_000
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             grow_i,
   output logic [VEC_W-1:0] snake_o
);
   import snake_pkg::*;

   localparam int unsigned LEN_W = $clog2(MAX_LEN + 1);

   logic             step_tick;
   logic             wrap;
   logic [LEN_W-1:0] len;
   snake_dir_e       dir;
   logic [VEC_W-1:0] vec;

   snake_tick_gen #(
      .DIV_TC (DIV_TC)
   ) tick_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (step_tick)
   );

   snake_len_ctrl #(
      .MIN_LEN (MIN_LEN),
      .MAX_LEN (MAX_LEN),
      .LEN_W   (LEN_W)
   ) len_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .grow_i (grow_i),
      .len_o  (len),
      .wrap_o (wrap)
   );

   snake_body #(
      .VEC_W   (VEC_W),
      .MIN_LEN (MIN_LEN),
      .MAX_LEN (MAX_LEN)
   ) body_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (step_tick),
      .grow_i (grow_i),
      .wrap_i (wrap),
      .vec_o  (vec),
      .dir_o  (dir)
   );

   assign snake_o = vec;

   // R9
   run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(snake_o) == int'(len));
   // R9
   contiguous_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((snake_o + (snake_o & (~snake_o + 1'b1))) & snake_o) == '0);
   // R8
   grow_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grow_i && step_tick |=> len != $past(len));

endmodule

// File: tb/snake_bounce_tb.sv
module snake_bounce_tb_top;

   localparam int W    = 18;
   localparam int LMIN = 2;
   localparam int LMAX = 6;
   localparam int DIV  = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         grow = 1'b0;
   logic [W-1:0] snake;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int m_lo, m_len, m_cnt;
   bit m_up;

   always #4 clk = ~clk;

   snake_bounce #(
      .VEC_W   (W),
      .MIN_LEN (LMIN),
      .MAX_LEN (LMAX),
      .DIV_TC  (DIV)
   ) dut_i (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .grow_i  (grow),
      .snake_o (snake)
   );

   function automatic logic [W-1:0] model_vec();
      return ((W'(1) << m_len) - W'(1)) << m_lo;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: snake_o actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic check_shape(input logic [W-1:0] act);
      logic [W-1:0] low;
      checks++;
      low = act & (~act + W'(1));
      if (((act + low) & act) != '0 || $countones(act) != m_len) begin
         errors++;
         $display("FAIL R9: snake_o actual=%b expected contiguous run of %0d", act, m_len);
      end
   endtask

   // advance the model by one edge; returns the tag of what happened
   function automatic string model_step(input bit g);
      bit    tick;
      bit    edge_tail;
      string tag;
      tick  = (m_cnt == 0);
      m_cnt = tick ? DIV - 1 : m_cnt - 1;
      if (g) begin
         if (m_len == LMAX) begin
            tag = "R7";
            if (m_up) m_lo = m_lo + (LMAX - LMIN);
            m_len = LMIN;
         end else begin
            edge_tail = m_up ? (m_lo == 0) : (m_lo + m_len == W);
            tag = edge_tail ? "R6" : (tick ? "R8" : "R5");
            if (m_up != edge_tail) m_lo = m_lo - 1;
            m_len = m_len + 1;
         end
      end else if (tick) begin
         tag = "R3";
         if (m_up) begin
            m_lo = m_lo + 1;
            if (m_lo + m_len == W) begin m_up = 1'b0; tag = "R4"; end
         end else begin
            m_lo = m_lo - 1;
            if (m_lo == 0) begin m_up = 1'b1; tag = "R4"; end
         end
      end else begin
         tag = "R2";
      end
      return tag;
   endfunction

   initial begin
      string tag;
      bit    g;
      bit    last_g;
      m_lo = 0; m_len = LMIN; m_cnt = DIV - 1; m_up = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", snake, W'(3));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", snake, W'(3));
      // the first edge after release was one divider count: model that
      tag = model_step(1'b0);
      last_g = 1'b0;
      for (int cyc = 0; cyc < 6000; cyc++) begin
         if (cyc < 2500) begin
            g = ((cyc % 7) == 3) || ((cyc % 11) == 0 && (cyc % 7) != 2 && (cyc % 7) != 4);
         end else begin
            g = !last_g && (((m_up && m_lo == 0) || (!m_up && m_lo + m_len == W))
                            || (m_cnt == 0 && (cyc % 3) == 0));
         end
         grow = g;
         tag = model_step(g);
         @(negedge clk);
         check(tag, snake, model_vec());
         check_shape(snake);
         last_g = g;
      end
      grow = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule